// File: doc/BRIEF.md
# Byte-Memory Target on a Command/Accept Bus

This block is a bus target that sits behind a point-to-point command interface and owns a small array of bytes. An initiator presents a command code, an address and, for writes, a data byte, and holds them until the target signals acceptance. A write command stores the byte. A read command returns the addressed byte together with a data-valid response in the same cycle as the acceptance.

Each instance covers one fixed, contiguous address window, which is set by parameters. The target ignores any command whose address falls outside that window. It gives no acceptance and no response, so a neighbouring target that covers the address can answer instead. Several instances can therefore share one command bus and each take its own slice of the address space.

Internally a three-state controller (idle, write, read) captures an accepted command, performs it during the following cycle and returns to idle. Every accepted command therefore occupies exactly two cycles.

Top module: `ocp_mem_target`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scmd_accept` is 0, `sresp` is 00 and `sdata` is 0.
- R2: A write (`mcmd` = 001) to an address inside the window, presented while the target is idle, is answered by `scmd_accept` = 1 for exactly one cycle. That cycle is the one after the command is first presented. The byte on `mdata` is stored and can be read back.
- R3: A read (`mcmd` = 010) inside the window is answered in the cycle after presentation with `scmd_accept` = 1, `sresp` = 01 (data valid) and `sdata` equal to the stored byte, all for exactly one cycle.
- R4: Outside the response cycle of a read, `sresp` is 00 and `sdata` is 0. A write's acceptance cycle carries `sresp` = 00.
- R5: Code 000 (idle) and the unused codes 011 to 111 cause no acceptance, no response and no change to memory.
- R6: A write or read whose address is below `BASE_ADDR`, or at or above `BASE_ADDR + DEPTH`, gets no acceptance and no response for as long as it is held. The memory is left unchanged.
- R7: After reset every byte of the array reads as 0.
- R8: A command is not accepted in the cycle it is first presented. During the cycle after acceptance the target ignores the bus, so each accepted command takes two cycles.
- R9: Address `BASE_ADDR + k` selects byte k. A write to one byte leaves its neighbours unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcmd | input | 3 | Command code: 000 idle, 001 write, 010 read |
| maddr | input | ADDR_W | Byte address of the command |
| mdata | input | DATA_W | Write data |
| scmd_accept | output | 1 | Command accepted, one cycle per command |
| sresp | output | 2 | Response: 00 none, 01 data valid |
| sdata | output | DATA_W | Read data, valid when `sresp` = 01 |

## Verification
The bench builds the target with a 13-bit address, 8-bit data, a window base of 0x100 and a depth of 64. That leaves addresses both below the window (0x0FF) and just above it (0x140) on the bus. The address 0x140 would alias onto byte 0 if the range check were missing, so a write there exposes a faulty decode through a later readback of 0x100. The small depth also puts the first and last bytes of the window within a handful of directed commands.

// File: rtl/ocp_tgt_pkg.sv
package ocp_tgt_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'b000,
    CMD_WRITE = 3'b001,
    CMD_READ  = 3'b010
  } cmd_code_e;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'b00,
    RESP_VALID = 2'b01
  } resp_code_e;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_WR,
    KIND_RD
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ
  } tgt_state_e;

endpackage

// File: rtl/ocp_tgt_decode.sv
module ocp_tgt_decode
  import ocp_tgt_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DEPTH = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [2:0]        mcmd,
  input  logic [ADDR_W-1:0] maddr,
  output cmd_kind_e         kind,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W:0] LO_EXT = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] HI_EXT = LO_EXT + (ADDR_W+1)'(DEPTH);

  logic [ADDR_W:0] addr_ext;
  logic [ADDR_W:0] offset;

  always_comb begin
    addr_ext = {1'b0, maddr};
    offset   = addr_ext - LO_EXT;
    hit      = (addr_ext >= LO_EXT) && (addr_ext < HI_EXT);
    idx      = offset[IDX_W-1:0];
  end

  always_comb begin
    unique case (mcmd)
      CMD_WRITE: kind = KIND_WR;
      CMD_READ:  kind = KIND_RD;
      default:   kind = KIND_NONE;
    endcase
  end

endmodule

// File: rtl/ocp_tgt_mem.sv
module ocp_tgt_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 256,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic cell_we;
      assign cell_we = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cells_q[g] <= '0;
        end else if (cell_we) begin
          cells_q[g] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_data = cells_q[rd_idx];

  // R2: a write strobe lands its byte in the addressed cell
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cells_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/ocp_tgt_ctrl.sv
module ocp_tgt_ctrl
  import ocp_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 256,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] mdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              scmd_accept,
  output logic [1:0]        sresp,
  output logic [DATA_W-1:0] sdata
);

  tgt_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              capture;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hit && kind == KIND_WR) begin
          state_d = ST_WRITE;
          capture = 1'b1;
        end else if (hit && kind == KIND_RD) begin
          state_d = ST_READ;
          capture = 1'b1;
        end
      end
      ST_WRITE: state_d = ST_IDLE;
      ST_READ:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    idx_d  = capture ? idx   : idx_q;
    data_d = capture ? mdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        idx_q  <= idx_d;
        data_q <= data_d;
      end
    end
  end

  always_comb begin
    mem_we      = (state_q == ST_WRITE);
    mem_idx     = idx_q;
    mem_wdata   = data_q;
    scmd_accept = (state_q != ST_IDLE);
    sresp       = (state_q == ST_READ) ? RESP_VALID : RESP_NONE;
    sdata       = (state_q == ST_READ) ? mem_rdata : '0;
  end

  // R2 R3: acceptance never lasts more than one cycle
  assert_accept_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scmd_accept |=> !scmd_accept);

  // R8: an in-window command seen while idle is accepted on the next cycle
  assert_accept_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scmd_accept && hit && kind != KIND_NONE) |=> scmd_accept);

  // R5 R6: nothing in window, no valid code -> no acceptance
  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scmd_accept && !(hit && kind != KIND_NONE)) |=> !scmd_accept);

  // R4: a response only ever rides with an acceptance
  assert_resp_with_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sresp != RESP_NONE) |-> (scmd_accept && sresp == RESP_VALID));

  // R3: a read acceptance carries a data-valid response
  assert_read_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!scmd_accept && hit && kind == KIND_RD)) |-> (sresp == RESP_VALID));

endmodule

// File: rtl/ocp_mem_target.sv
module ocp_mem_target
  import ocp_tgt_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int DEPTH = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mcmd,
  input  logic [ADDR_W-1:0] maddr,
  input  logic [DATA_W-1:0] mdata,
  output logic              scmd_accept,
  output logic [1:0]        sresp,
  output logic [DATA_W-1:0] sdata
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cmd_kind_e         kind;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  ocp_tgt_decode #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .mcmd(mcmd), .maddr(maddr), .kind(kind), .hit(hit), .idx(idx)
  );

  ocp_tgt_ctrl #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .kind(kind), .hit(hit), .idx(idx),
    .mdata(mdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_idx(mem_idx), .mem_wdata(mem_wdata),
    .scmd_accept(scmd_accept), .sresp(sresp), .sdata(sdata)
  );

  ocp_tgt_mem #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_we), .wr_idx(mem_idx),
    .wr_data(mem_wdata), .rd_idx(mem_idx), .rd_data(mem_rdata)
  );

  // R1: outputs quiet immediately after reset release
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!scmd_accept && sresp == RESP_NONE));

endmodule

// File: tb/ocp_mem_target_tb_top.sv
module ocp_mem_target_tb_top;

  localparam int AW = 13;
  localparam int DW = 8;
  localparam int DEP = 64;
  localparam logic [AW-1:0] BASE = 13'h0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mcmd = 3'b000;
  logic [AW-1:0] maddr = '0;
  logic [DW-1:0] mdata = '0;
  logic          scmd_accept;
  logic [1:0]    sresp;
  logic [DW-1:0] sdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ocp_mem_target #(
    .ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP), .BASE_ADDR(BASE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mcmd(mcmd), .maddr(maddr), .mdata(mdata),
    .scmd_accept(scmd_accept), .sresp(sresp), .sdata(sdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(req, {31'b0, scmd_accept}, 32'd0);
    chk(req, {30'b0, sresp}, 32'd0);
    chk(req, {24'b0, sdata}, 32'd0);
  endtask

  // in-window write: presented at a falling edge, accepted one cycle later
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    mcmd = 3'b001; maddr = a; mdata = d;
    #1 chk("R8 not accepted in presentation cycle", {31'b0, scmd_accept}, 32'd0);
    @(posedge clk); #1;
    chk("R2 write accepted", {31'b0, scmd_accept}, 32'd1);
    chk("R4 write carries no response", {30'b0, sresp}, 32'd0);
    @(negedge clk);
    mcmd = 3'b000;
    @(posedge clk); #1;
    chk("R2 accept lasts one cycle", {31'b0, scmd_accept}, 32'd0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    mcmd = 3'b010; maddr = a; mdata = 8'hEE;
    #1 chk("R8 not accepted in presentation cycle", {31'b0, scmd_accept}, 32'd0);
    @(posedge clk); #1;
    chk("R3 read accepted", {31'b0, scmd_accept}, 32'd1);
    chk("R3 read response DVA", {30'b0, sresp}, 32'd1);
    chk(req, {24'b0, sdata}, {24'b0, exp});
    @(negedge clk);
    mcmd = 3'b000;
    @(posedge clk); #1;
    quiet("R4 quiet after read");
  endtask

  // command that must be ignored, held for several cycles
  task automatic do_ignored(input logic [2:0] c, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string req);
    @(negedge clk);
    mcmd = c; maddr = a; mdata = d;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      quiet(req);
    end
    @(negedge clk);
    mcmd = 3'b000;
  endtask

  task automatic test_reset();
    #1 quiet("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    quiet("R1 after reset");
  endtask

  task automatic test_zero_init();
    do_read(BASE, 8'h00, "R7 first byte zero");
    do_read(BASE + 13'd63, 8'h00, "R7 last byte zero");
    do_read(BASE + 13'd17, 8'h00, "R7 middle byte zero");
  endtask

  task automatic test_write_read();
    do_write(BASE, 8'hA5);
    do_write(BASE + 13'd63, 8'h5A);
    do_write(BASE + 13'h20, 8'hFF);
    do_read(BASE, 8'hA5, "R2 R3 first byte readback");
    do_read(BASE + 13'd63, 8'h5A, "R2 R3 last byte readback");
    do_read(BASE + 13'h20, 8'hFF, "R9 mapped byte readback");
    do_read(BASE + 13'h21, 8'h00, "R9 neighbour untouched");
    do_read(BASE + 13'h1F, 8'h00, "R9 neighbour below untouched");
    do_write(BASE + 13'h20, 8'h3C);
    do_read(BASE + 13'h20, 8'h3C, "R2 overwrite");
  endtask

  task automatic test_out_of_range();
    do_ignored(3'b001, 13'h0140, 8'h77, "R6 write above window ignored");
    do_ignored(3'b001, 13'h00FF, 8'h66, "R6 write below window ignored");
    do_ignored(3'b010, 13'h0140, 8'h00, "R6 read above window ignored");
    do_ignored(3'b010, 13'h1FFF, 8'h00, "R6 read top address ignored");
    do_read(BASE, 8'hA5, "R6 memory unchanged by aliased write");
  endtask

  task automatic test_other_codes();
    for (int c = 3; c < 8; c++) begin
      do_ignored(3'(c), BASE + 13'd1, 8'h33, "R5 unused code ignored");
    end
    do_ignored(3'b000, BASE + 13'd1, 8'h33, "R5 idle code ignored");
    do_read(BASE + 13'd1, 8'h00, "R5 memory unchanged by unused codes");
  endtask

  // held command: accepted once, then re-accepted two cycles per command
  task automatic test_held();
    @(negedge clk);
    mcmd = 3'b010; maddr = BASE; mdata = 8'h00;
    @(posedge clk); #1;
    chk("R8 held read first accept", {31'b0, scmd_accept}, 32'd1);
    @(posedge clk); #1;
    chk("R8 bus ignored after accept", {31'b0, scmd_accept}, 32'd0);
    @(posedge clk); #1;
    chk("R8 held read accepted again", {31'b0, scmd_accept}, 32'd1);
    chk("R8 held read data", {24'b0, sdata}, 32'hA5);
    @(negedge clk);
    mcmd = 3'b000;
    @(posedge clk); #1;
    quiet("R8 idle after release");
  endtask

  initial begin
    test_reset();
    test_zero_init();
    test_write_read();
    test_out_of_range();
    test_other_codes();
    test_held();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule